// File: doc/BRIEF.md
# Vector Destination Element Merger

This block forms the value written back to one physical vector register after a vector operation. Each element of the register is classified by its global element number: it is either before the restart point, an active body element, a body element switched off by the mask, or part of the tail past the vector length. The block then picks, per element, the freshly computed result, the old destination contents, or an all-ones fill.

One call handles one register of a group. The caller supplies the global element number of the register's first element, so a group of registers is processed by issuing one call per member with a rising base number. Element width is chosen per call and the result is registered, one cycle after the request.

Top module: `vreg_wb_merge`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock and `out_data` is registered with the same one-cycle delay; a synchronous reset clears `out_valid` and `out_data` to zero.
- R2: `elem_sz` selects the element width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits); local element k occupies bits [k*width +: width] and has global number `base_idx` + k.
- R3: A body element (`vstart` ≤ global < `vl`) whose mask allows it, because `vm` = 1 or `mask_bits`[global] = 1, takes its bits from `new_data`.
- R4: With `vm` = 0, a body element whose mask bit is 0 keeps its `old_data` bits when `vma` = 0.
- R5: With `vm` = 0, a body element whose mask bit is 0 is filled with all ones when `vma` = 1.
- R6: A tail element (global ≥ `vl`) keeps `old_data` when `vta` = 0 and is all ones when `vta` = 1, whatever `vm` and its mask bit are.
- R7: An element with global number below `vstart` keeps `old_data`, whatever the mask, `vm`, `vma` and `vta`.
- R8: When `vstart` ≥ `vl`, the whole output equals `old_data`, tail included.
- R9: The mask bit of an element is `mask_bits`[global number], so the base offset selects which mask bits apply; a global number of VLEN or more reads a mask bit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| elem_sz | input | 2 | Element width code |
| vm | input | 1 | 1 = unmasked, 0 = mask applies |
| vta | input | 1 | Tail fill policy (1 = all ones) |
| vma | input | 1 | Masked-off fill policy (1 = all ones) |
| vl | input | IDX_W | Vector length in elements |
| vstart | input | IDX_W | First element to process |
| base_idx | input | IDX_W | Global number of this register's first element |
| mask_bits | input | VLEN | Mask register, one bit per global element |
| old_data | input | VLEN | Current destination contents |
| new_data | input | VLEN | Computed result |
| out_valid | output | 1 | Result strobe |
| out_data | output | VLEN | Merged destination word |

## Verification
Assertions watch every cycle for the one-cycle valid delay, for an untouched register whenever the restart point is at or beyond the vector length, for a register lying wholly in the tail matching its fill policy, and for a fully active unmasked register passing the result through. Mixed registers, where prestart, active, masked-off and tail elements share one word at each element width, and the base offset steering which mask bits apply, are shown only by the bench's scenarios against its element-by-element model.

// File: rtl/vreg_wb_pkg.sv
package vreg_wb_pkg;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_B64 = 2'd3
  } elem_sz_t;

  typedef enum logic [1:0] {
    EC_PRESTART = 2'd0,
    EC_ACTIVE   = 2'd1,
    EC_MASKOFF  = 2'd2,
    EC_TAIL     = 2'd3
  } elem_cls_t;

endpackage

// File: rtl/vreg_wb_lane_index.sv
module vreg_wb_lane_index #(
  parameter int IDX_W = 8,
  parameter int LANE  = 0
) (
  input  logic [1:0]       elem_sz,
  input  logic [IDX_W-1:0] base_idx,
  output logic [IDX_W:0]   gidx
);
  import vreg_wb_pkg::*;

  localparam logic [IDX_W-1:0] LANE_V = IDX_W'(LANE);

  logic [IDX_W-1:0] local_k;

  // A byte lane belongs to element (lane / bytes-per-element).
  always_comb begin
    unique case (elem_sz_t'(elem_sz))
      SZ_B8:   local_k = LANE_V;
      SZ_B16:  local_k = LANE_V >> 1;
      SZ_B32:  local_k = LANE_V >> 2;
      default: local_k = LANE_V >> 3;
    endcase
    gidx = {1'b0, base_idx} + {1'b0, local_k};
  end

endmodule

// File: rtl/vreg_wb_lane_class.sv
module vreg_wb_lane_class #(
  parameter int VLEN  = 128,
  parameter int IDX_W = 8
) (
  input  logic [IDX_W:0]   gidx,
  input  logic [IDX_W-1:0] vl,
  input  logic [IDX_W-1:0] vstart,
  input  logic             vm,
  input  logic [VLEN-1:0]  mask_bits,
  output vreg_wb_pkg::elem_cls_t cls
);
  import vreg_wb_pkg::*;

  localparam int MASK_AW = $clog2(VLEN);

  logic in_range;
  logic mbit;

  always_comb begin
    in_range = gidx < (IDX_W+1)'(VLEN);
    mbit     = in_range ? mask_bits[gidx[MASK_AW-1:0]] : 1'b0;
    if (gidx < {1'b0, vstart})
      cls = EC_PRESTART;
    else if (gidx >= {1'b0, vl})
      cls = EC_TAIL;          // mask is not consulted past vl
    else if (!vm && !mbit)
      cls = EC_MASKOFF;
    else
      cls = EC_ACTIVE;
  end

endmodule

// File: rtl/vreg_wb_byte_pick.sv
module vreg_wb_byte_pick (
  input  vreg_wb_pkg::elem_cls_t cls,
  input  logic       frozen,
  input  logic       vta,
  input  logic       vma,
  input  logic [7:0] old_b,
  input  logic [7:0] new_b,
  output logic [7:0] out_b
);
  import vreg_wb_pkg::*;

  always_comb begin
    if (frozen) begin
      out_b = old_b;
    end else begin
      unique case (cls)
        EC_ACTIVE:  out_b = new_b;
        EC_MASKOFF: out_b = vma ? 8'hFF : old_b;
        EC_TAIL:    out_b = vta ? 8'hFF : old_b;
        default:    out_b = old_b;
      endcase
    end
  end

endmodule

// File: rtl/vreg_wb_merge.sv
module vreg_wb_merge #(
  parameter int VLEN  = 128,
  parameter int IDX_W = $clog2(VLEN) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       elem_sz,
  input  logic             vm,
  input  logic             vta,
  input  logic             vma,
  input  logic [IDX_W-1:0] vl,
  input  logic [IDX_W-1:0] vstart,
  input  logic [IDX_W-1:0] base_idx,
  input  logic [VLEN-1:0]  mask_bits,
  input  logic [VLEN-1:0]  old_data,
  input  logic [VLEN-1:0]  new_data,
  output logic             out_valid,
  output logic [VLEN-1:0]  out_data
);
  import vreg_wb_pkg::*;

  localparam int NBYTES = VLEN / 8;

  logic            frozen;
  logic [VLEN-1:0] merged;

  assign frozen = vstart >= vl;

  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_lane
    logic [IDX_W:0] gidx;
    elem_cls_t      cls;

    vreg_wb_lane_index #(.IDX_W(IDX_W), .LANE(gb)) u_idx (
      .elem_sz  (elem_sz),
      .base_idx (base_idx),
      .gidx     (gidx)
    );

    vreg_wb_lane_class #(.VLEN(VLEN), .IDX_W(IDX_W)) u_cls (
      .gidx      (gidx),
      .vl        (vl),
      .vstart    (vstart),
      .vm        (vm),
      .mask_bits (mask_bits),
      .cls       (cls)
    );

    vreg_wb_byte_pick u_pick (
      .cls    (cls),
      .frozen (frozen),
      .vta    (vta),
      .vma    (vma),
      .old_b  (old_data[gb*8 +: 8]),
      .new_b  (new_data[gb*8 +: 8]),
      .out_b  (merged[gb*8 +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= merged;
    end
  end

  // R1: result strobe trails the request by one cycle
  p_valid_delay_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R8: restart point at or past vl leaves the register untouched
  p_frozen_keep_r8: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst && (vstart >= vl)) |-> (out_data == $past(old_data)));

  // R6: register wholly in the tail follows the tail policy
  p_all_tail_r6: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst && (vstart < vl) && (vl <= base_idx)) |->
      (out_data == ($past(vta) ? {VLEN{1'b1}} : $past(old_data))));

  // R3: unmasked, fully active first register passes the result through
  p_full_body_r3: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst && vm && (vstart == '0) && (base_idx == '0) &&
          (vl == IDX_W'(VLEN))) |-> (out_data == $past(new_data)));

endmodule

// File: tb/vreg_wb_merge_tb.sv
`timescale 1ns/1ps
module vreg_wb_merge_tb;
  localparam int VLEN  = 128;
  localparam int IDX_W = $clog2(VLEN) + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [1:0]       elem_sz = '0;
  logic             vm = 1'b1, vta = 1'b0, vma = 1'b0;
  logic [IDX_W-1:0] vl = '0, vstart = '0, base_idx = '0;
  logic [VLEN-1:0]  mask_bits = '0, old_data = '0, new_data = '0;
  logic             out_valid;
  logic [VLEN-1:0]  out_data;

  int total = 0;
  int fails = 0;

  logic [VLEN-1:0] exp_q[$];
  string           tag_q[$];

  always #4 clk = ~clk;

  vreg_wb_merge #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .elem_sz(elem_sz),
    .vm(vm), .vta(vta), .vma(vma), .vl(vl), .vstart(vstart),
    .base_idx(base_idx), .mask_bits(mask_bits), .old_data(old_data),
    .new_data(new_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [VLEN-1:0] model(input int sz, input bit m_vm,
      input bit m_vta, input bit m_vma, input int m_vl, input int m_vs,
      input int m_base, input logic [VLEN-1:0] m_mask,
      input logic [VLEN-1:0] m_old, input logic [VLEN-1:0] m_new);
    logic [VLEN-1:0] r = m_old;
    int w = 8 << sz;
    if (m_vs >= m_vl) return m_old;
    for (int k = 0; k < VLEN / w; k++) begin
      int g = m_base + k;
      int src;  // 0 old, 1 new, 2 ones
      if (g < m_vs) src = 0;
      else if (g >= m_vl) src = m_vta ? 2 : 0;
      else if (!m_vm && !(g < VLEN && m_mask[g])) src = m_vma ? 2 : 0;
      else src = 1;
      for (int b = 0; b < w; b++)
        r[k*w + b] = (src == 1) ? m_new[k*w + b] : (src == 2) ? 1'b1 : m_old[k*w + b];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input int sz, input bit s_vm,
      input bit s_vta, input bit s_vma, input int s_vl, input int s_vs,
      input int s_base, input logic [VLEN-1:0] s_mask,
      input logic [VLEN-1:0] s_old, input logic [VLEN-1:0] s_new);
    @(negedge clk);
    in_valid  = 1'b1;
    elem_sz   = 2'(sz);
    vm = s_vm; vta = s_vta; vma = s_vma;
    vl = IDX_W'(s_vl); vstart = IDX_W'(s_vs); base_idx = IDX_W'(s_base);
    mask_bits = s_mask; old_data = s_old; new_data = s_new;
    exp_q.push_back(model(sz, s_vm, s_vta, s_vma, s_vl, s_vs, s_base,
                          s_mask, s_old, s_new));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor: pop expected result whenever the design presents one
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        total++; fails++;
        $display("FAIL R1: actual unexpected result expected none");
      end else begin
        logic [VLEN-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    logic [VLEN-1:0] od, nd;
    od = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
    nd = 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", {{(VLEN-1){1'b0}}, out_valid}, '0);
    check("R1 reset data", out_data, '0);
    rst = 1'b0;

    // back-to-back stream of requests
    send("R3 unmasked full",      0, 1, 0, 0, 128, 0, 0,  '0, od, nd);
    send("R2 R6 e16 tail kept",   1, 1, 0, 0, 5,   0, 0,  '0, od, nd);
    send("R2 R6 e16 tail ones",   1, 1, 1, 0, 5,   0, 0,  '0, od, nd);
    send("R4 e32 masked kept",    2, 0, 0, 0, 4,   0, 0,  128'h5, od, nd);
    send("R5 e32 masked ones",    2, 0, 0, 1, 4,   0, 0,  128'h5, od, nd);
    send("R6 mask ignored in tail", 0, 0, 1, 0, 9, 0, 0,  128'hFF00, od, nd);
    send("R7 prestart unmasked",  0, 1, 1, 1, 10,  3, 0,  '0, od, nd);
    send("R7 prestart masked",    0, 0, 1, 1, 10,  3, 0,  '0, od, nd);
    send("R8 vstart equals vl",   0, 1, 1, 1, 10,  10, 0, '1, od, nd);
    send("R8 vl zero",            1, 0, 1, 1, 0,   0, 0,  '0, od, nd);
    send("R9 base offset mask",   0, 0, 1, 1, 28,  0, 16, 128'h00A5_0000 | 128'h3C, od, nd);
    send("R2 R6 e64 base two",    3, 1, 1, 0, 3,   0, 2,  '0, od, nd);
    send("R6 whole reg tail",     2, 1, 1, 0, 8,   0, 8,  '1, od, nd);
    send("R9 mask past VLEN",     0, 0, 0, 1, 128, 0, 120,'1, od, nd);
    idle();
    @(negedge clk);
    check("R1 valid drops", {{(VLEN-1){1'b0}}, out_valid}, '0);
    repeat (2) @(negedge clk);
    check("R1 queue drained", VLEN'(exp_q.size()), '0);
    report();
  end

endmodule